// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Bus Snooping

This block is a byte-wide cache placed between a CPU port and a main-memory port. Each memory block of four bytes can be held in exactly one line of the cache. The line is selected by the block number modulo the line count. A tag is kept beside every line to tell which block the line currently holds, and a valid bit tells whether the tag means anything. A read that hits returns the stored byte in the cycle of the request and causes no memory traffic. A read that misses loads the whole block from memory, one byte per beat in ascending offset order. The requested byte is handed to the CPU in the same beat that writes it into the line.

Every CPU write is passed through to memory as a single byte write. When the addressed line already holds that block, the write also updates the line. A write that misses does not take a line. A snoop port watches memory writes made by other bus masters. Any valid line that holds the written block is invalidated, so that later reads fetch fresh data.

The memory port uses a request/ready handshake. A beat completes on every clock edge at which both request and ready are high. The CPU holds its request, and every request field, stable until it sees done at a clock edge.

Top module: `wt_snoop_cache`

## Requirements
- R1: An address splits, from the top, into a tag, a line index of IDX_W bits and a byte offset of OFF_W bits (bits [1:0] by default, index bits [7:2] by default). Two blocks with the same index and different tags evict each other.
- R2: A read whose indexed line is valid and holds the address tag returns the stored byte with done in the cycle of the request, and makes no memory request.
- R3: A read miss makes exactly four memory reads of the addressed block, at offsets 0, 1, 2 and 3 in that order.
- R4: During a read miss, the CPU receives done together with memory data in the beat whose offset equals the requested offset.
- R5: Every CPU write makes exactly one memory write with the CPU address and byte. Done is given in the beat that memory accepts it, and the write's address and data stay stable while ready is low.
- R6: A write that hits updates the cached byte, so that a later read hit returns it. A write that misses allocates no line, so that a later read of that block misses.
- R7: A snoop write to a block held in a valid line invalidates that line. A snoop to the same index with a different tag leaves the line valid.
- R8: A snoop of the block being filled, arriving during the fill, leaves that line invalid once the fill completes.
- R9: Reset clears every valid bit, so the first read of any address after reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | CPU request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wdata | input | DATA_W | CPU write byte |
| cpu_rdata | output | DATA_W | Read byte, valid with done |
| cpu_done | output | 1 | Request completes at this edge |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write byte |
| mem_rdata | input | DATA_W | Memory read byte |
| mem_rdy | input | 1 | Memory accepts/returns the beat |
| snp_valid | input | 1 | Another master writes memory this cycle |
| snp_addr | input | ADDR_W | Address of that foreign write |

## Verification
Directed sequences cover several patterns. Repeated reads of one block tell hits from misses. Reads of two tags on one index show that each evicts the other. Write-then-read pairs show hit update apart from no-allocate on a miss. Snoops are sent both to the cached tag and to a foreign tag on the same index. A snoop is also aimed at a block while its fill is running. A seeded random mix of reads, writes and snoops then runs over a few tags and indices, so that conflicts and invalidations are frequent. Each read is judged on two things. The first is its data against a memory model. The second is its memory-read beat count, zero or four, against a reference tag/valid table.

// File: rtl/wt_cache_pkg.sv
`timescale 1ns/1ps
package wt_cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } cstate_e;
endpackage

// File: rtl/wt_line_store.sv
`timescale 1ns/1ps
module wt_line_store #(
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 16,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IDX_W-1:0]              lk_idx,
    output logic                          lk_valid,
    output logic [TAG_W-1:0]              lk_tag,
    output logic [(DATA_W<<OFF_W)-1:0]    lk_line,
    input  logic [IDX_W-1:0]              sn_idx,
    output logic                          sn_valid,
    output logic [TAG_W-1:0]              sn_tag,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [OFF_W-1:0]              wr_off,
    input  logic [DATA_W-1:0]             wr_byte,
    input  logic                          set_en,
    input  logic [IDX_W-1:0]              set_idx,
    input  logic [TAG_W-1:0]              set_tag,
    input  logic                          clr_en,
    input  logic [IDX_W-1:0]              clr_idx,
    input  logic                          kill_en,
    input  logic [IDX_W-1:0]              kill_idx
);
    localparam int LINES = 1 << IDX_W;
    localparam int NLANE = 1 << OFF_W;

    logic [LINES-1:0] valid_d, valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // later assignments win: a snoop kill overrides a tag install
    always_comb begin
        valid_d = valid_q;
        if (set_en)  valid_d[set_idx]  = 1'b1;
        if (clr_en)  valid_d[clr_idx]  = 1'b0;
        if (kill_en) valid_d[kill_idx] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (set_en) tag_q[set_idx] <= set_tag;
    end

    for (genvar L = 0; L < NLANE; L++) begin : g_lane
        logic [DATA_W-1:0] lane_q [LINES];
        always_ff @(posedge clk) begin
            if (wr_en && wr_off == OFF_W'(L)) lane_q[wr_idx] <= wr_byte;
        end
        assign lk_line[L*DATA_W +: DATA_W] = lane_q[lk_idx];
    end

    assign lk_valid = valid_q[lk_idx];
    assign lk_tag   = tag_q[lk_idx];
    assign sn_valid = valid_q[sn_idx];
    assign sn_tag   = tag_q[sn_idx];
endmodule

// File: rtl/wt_snoop_probe.sv
`timescale 1ns/1ps
module wt_snoop_probe #(
    parameter int BLK_W = 22,
    parameter int IDX_W = 6,
    localparam int TAG_W = BLK_W - IDX_W
) (
    input  logic             snp_valid,
    input  logic [BLK_W-1:0] snp_blk,
    output logic [IDX_W-1:0] probe_idx,
    input  logic             line_valid,
    input  logic [TAG_W-1:0] line_tag,
    output logic             kill_en,
    output logic [IDX_W-1:0] kill_idx
);
    always_comb begin
        probe_idx = snp_blk[IDX_W-1:0];
        kill_idx  = probe_idx;
        kill_en   = snp_valid && line_valid && (line_tag == snp_blk[BLK_W-1:IDX_W]);
    end
endmodule

// File: rtl/wt_cache_ctrl.sv
`timescale 1ns/1ps
module wt_cache_ctrl
    import wt_cache_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 6,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 8,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
    localparam int BLK_W = ADDR_W - OFF_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_req,
    input  logic                       cpu_we,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [DATA_W-1:0]          cpu_wdata,
    output logic [DATA_W-1:0]          cpu_rdata,
    output logic                       cpu_done,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [DATA_W-1:0]          mem_wdata,
    input  logic [DATA_W-1:0]          mem_rdata,
    input  logic                       mem_rdy,
    input  logic                       snp_valid,
    input  logic [BLK_W-1:0]           snp_blk,
    output logic [IDX_W-1:0]           lk_idx,
    input  logic                       lk_valid,
    input  logic [TAG_W-1:0]           lk_tag,
    input  logic [(DATA_W<<OFF_W)-1:0] lk_line,
    output logic                       wr_en,
    output logic [IDX_W-1:0]           wr_idx,
    output logic [OFF_W-1:0]           wr_off,
    output logic [DATA_W-1:0]          wr_byte,
    output logic                       set_en,
    output logic [IDX_W-1:0]           set_idx,
    output logic [TAG_W-1:0]           set_tag,
    output logic                       clr_en,
    output logic [IDX_W-1:0]           clr_idx
);
    typedef struct packed {
        cstate_e           st;
        logic [OFF_W-1:0]  beat;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              poison;
    } ctrl_t;

    ctrl_t q, d;
    logic [ADDR_W-1:0] cur_addr;
    logic              hit, blk_snooped;

    always_comb begin
        d         = q;
        cpu_rdata = '0;
        cpu_done  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.addr;
        mem_wdata = q.wdata;
        wr_en     = 1'b0;
        wr_off    = q.beat;
        wr_byte   = mem_rdata;
        set_en    = 1'b0;
        clr_en    = 1'b0;

        cur_addr    = (q.st == ST_IDLE) ? cpu_addr : q.addr;
        lk_idx      = cur_addr[OFF_W +: IDX_W];
        wr_idx      = lk_idx;
        set_idx     = lk_idx;
        clr_idx     = lk_idx;
        set_tag     = cur_addr[ADDR_W-1 -: TAG_W];
        hit         = lk_valid && (lk_tag == cur_addr[ADDR_W-1 -: TAG_W]);
        blk_snooped = snp_valid && (snp_blk == q.addr[ADDR_W-1:OFF_W]);

        unique case (q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    d.addr = cpu_addr;
                    if (cpu_we) begin
                        d.st    = ST_WRITE;
                        d.wdata = cpu_wdata;
                    end else if (hit) begin
                        cpu_done  = 1'b1;
                        cpu_rdata = lk_line[cpu_addr[OFF_W-1:0]*DATA_W +: DATA_W];
                    end else begin
                        d.st     = ST_FILL;
                        d.beat   = '0;
                        d.poison = 1'b0;
                        clr_en   = 1'b1;
                    end
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {q.addr[ADDR_W-1:OFF_W], q.beat};
                if (blk_snooped) d.poison = 1'b1;
                if (mem_rdy) begin
                    wr_en = 1'b1;
                    if (q.beat == q.addr[OFF_W-1:0]) begin
                        cpu_done  = 1'b1;
                        cpu_rdata = mem_rdata;
                    end
                    d.beat = q.beat + 1'b1;
                    if (&q.beat) begin
                        d.st   = ST_IDLE;
                        set_en = !q.poison && !blk_snooped;
                    end
                end
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                wr_off  = q.addr[OFF_W-1:0];
                wr_byte = q.wdata;
                if (mem_rdy) begin
                    cpu_done = 1'b1;
                    wr_en    = hit;
                    d.st     = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/wt_snoop_cache.sv
`timescale 1ns/1ps
module wt_snoop_cache #(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 6,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rdy,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr
);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int LINE_W = DATA_W << OFF_W;

    logic [BLK_W-1:0]  snp_blk;
    logic [IDX_W-1:0]  lk_idx, sn_idx, wr_idx, set_idx, clr_idx, kill_idx;
    logic              lk_valid, sn_valid, wr_en, set_en, clr_en, kill_en;
    logic [TAG_W-1:0]  lk_tag, sn_tag, set_tag;
    logic [LINE_W-1:0] lk_line;
    logic [OFF_W-1:0]  wr_off;
    logic [DATA_W-1:0] wr_byte;

    assign snp_blk = snp_addr[ADDR_W-1:OFF_W];

    wt_cache_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_ctrl (
        .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata, .cpu_done,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_rdy,
        .snp_valid, .snp_blk, .lk_idx, .lk_valid, .lk_tag, .lk_line,
        .wr_en, .wr_idx, .wr_off, .wr_byte, .set_en, .set_idx, .set_tag,
        .clr_en, .clr_idx
    );

    wt_snoop_probe #(.BLK_W(BLK_W), .IDX_W(IDX_W)) u_probe (
        .snp_valid, .snp_blk, .probe_idx(sn_idx), .line_valid(sn_valid),
        .line_tag(sn_tag), .kill_en, .kill_idx
    );

    wt_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_store (
        .clk, .rst_n, .lk_idx, .lk_valid, .lk_tag, .lk_line,
        .sn_idx, .sn_valid, .sn_tag, .wr_en, .wr_idx, .wr_off, .wr_byte,
        .set_en, .set_idx, .set_tag, .clr_en, .clr_idx, .kill_en, .kill_idx
    );
endmodule

// File: rtl/wt_snoop_cache_chk.sv
`timescale 1ns/1ps
module wt_snoop_cache_chk #(
    parameter int ADDR_W = 24,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_we,
    input logic              cpu_done,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_rdy,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] mem_rdata
);
    // R3
    fill_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && !mem_we |-> mem_addr[OFF_W-1:0] == '0);

    // R3
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_rdy && mem_addr[OFF_W-1:0] != '1 |=>
        mem_req && !mem_we &&
        mem_addr[OFF_W-1:0] == OFF_W'($past(mem_addr[OFF_W-1:0]) + 1'b1) &&
        mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]));

    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && !mem_rdy |=> mem_req && mem_we && $stable(mem_addr) && $stable(mem_wdata));

    // R5
    wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done && cpu_we |-> mem_req && mem_we && mem_rdy);

    // R4
    fwd_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done && mem_req && !mem_we |-> mem_rdy && cpu_rdata == mem_rdata);

    // R2
    hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done && !mem_req |-> !cpu_we);
endmodule

bind wt_snoop_cache wt_snoop_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/wt_snoop_cache_test.sv
`timescale 1ns/1ps
module wt_snoop_cache_test;
    localparam int AW = 24, IW = 6, OW = 2, DW = 8;
    localparam int LINES = 1 << IW;
    localparam int TW = AW - IW - OW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_req = 0, cpu_we = 0, cpu_done;
    logic [AW-1:0] cpu_addr = '0, mem_addr, snp_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, cpu_rdata, mem_wdata, mem_rdata = '0;
    logic mem_req, mem_we, mem_rdy = 0, snp_valid = 0;

    int checks = 0, fails = 0, cycles = 0;
    int rd_beats = 0, wr_beats = 0;
    logic [AW-1:0] fill_log [4];
    logic [AW-1:0] wr_last_addr;
    logic [DW-1:0] wr_last_data;
    logic [DW-1:0] mem [int];
    bit ref_valid [LINES];
    logic [TW-1:0] ref_tag [LINES];

    always #2.5 clk = ~clk;

    wt_snoop_cache #(.ADDR_W(AW), .IDX_W(IW), .OFF_W(OW), .DATA_W(DW)) uut (.*);

    function automatic logic [DW-1:0] rd_mem(input logic [AW-1:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // memory responder: decides each beat just after the falling edge
    always @(negedge clk) begin
        if (mem_req && ($urandom % 4 != 0)) begin
            mem_rdy = 1'b1;
            if (mem_we) begin
                mem[int'(mem_addr)] = mem_wdata;
                wr_last_addr = mem_addr;
                wr_last_data = mem_wdata;
                wr_beats++;
            end else begin
                mem_rdata = rd_mem(mem_addr);
                fill_log[rd_beats % 4] = mem_addr;
                rd_beats++;
            end
        end else begin
            mem_rdy = 1'b0;
        end
    end

    task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int lat);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; lat = 0;
        #1;
        while (!cpu_done) begin
            @(negedge clk); #1; lat++;
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 0;
        @(negedge clk); #1;
        while (mem_req) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string rq, input bit poison);
        int b0, lat, idx;
        logic [DW-1:0] rd;
        bit eh;
        idx = int'(a[OW +: IW]);
        eh = ref_valid[idx] && ref_tag[idx] == a[AW-1 -: TW];
        b0 = rd_beats;
        cpu_op(1'b0, a, '0, rd, lat);
        chk(rd == rd_mem(a), rq, rd, rd_mem(a));
        if (eh) begin
            chk(rd_beats - b0 == 0, "R2 no traffic on hit", rd_beats - b0, 0);
            chk(lat == 0, "R2 hit latency", lat, 0);
        end else begin
            chk(rd_beats - b0 == 4, "R3 fill beats", rd_beats - b0, 4);
            for (int k = 0; k < 4; k++)
                chk(fill_log[k] == {a[AW-1:OW], 2'(k)}, "R3 fill order", fill_log[k], {a[AW-1:OW], 2'(k)});
            ref_valid[idx] = !poison;
            ref_tag[idx] = a[AW-1 -: TW];
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int w0, r0, lat;
        logic [DW-1:0] rd;
        w0 = wr_beats; r0 = rd_beats;
        cpu_op(1'b1, a, d, rd, lat);
        chk(wr_beats - w0 == 1, "R5 write beats", wr_beats - w0, 1);
        chk(wr_last_addr == a && wr_last_data == d, "R5 write addr/data", {wr_last_addr, wr_last_data}, {a, d});
        chk(rd_beats - r0 == 0, "R6 write no allocate", rd_beats - r0, 0);
    endtask

    task automatic snoop(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int idx;
        idx = int'(a[OW +: IW]);
        @(negedge clk);
        snp_valid = 1; snp_addr = a;
        mem[int'(a)] = d;
        @(negedge clk);
        snp_valid = 0;
        if (ref_valid[idx] && ref_tag[idx] == a[AW-1 -: TW]) ref_valid[idx] = 0;
    endtask

    function automatic bit ref_hit(input logic [AW-1:0] a);
        return ref_valid[int'(a[OW +: IW])] && ref_tag[int'(a[OW +: IW])] == a[AW-1 -: TW];
    endfunction

    initial begin
        logic [AW-1:0] a, b, c, t;
        int s;
        s = $urandom(32'd4913);
        for (int i = 0; i < LINES; i++) ref_valid[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        chk(cpu_done == 0 && mem_req == 0, "R9 reset outputs", {cpu_done, mem_req}, 0);

        // R9: first access after reset misses
        a = 24'h012304;
        chk(!ref_hit(a), "R9 cold miss expected", ref_hit(a), 0);
        do_read(a, "R9 cold read data", 0);
        do_read(a + 3, "R2 hit data", 0);
        chk(ref_hit(a), "R2 line valid after fill", ref_hit(a), 1);

        // R4: miss on a non-zero offset, byte forwarded mid-fill
        do_read(24'h0456AB, "R4 forwarded byte", 0);

        // R1: same index, different tag evicts
        b = a ^ 24'h000100;
        do_read(b, "R1 conflict read", 0);
        chk(!ref_hit(a), "R1 eviction", ref_hit(a), 0);
        do_read(a + 1, "R1 reload after eviction", 0);

        // R6: write hit updates, write miss does not allocate
        do_write(a + 2, 8'hC3);
        do_read(a + 2, "R6 write hit data", 0);
        c = 24'h7F0010;
        do_write(c, 8'h3C);
        chk(!ref_hit(c), "R6 no allocate model", ref_hit(c), 0);
        do_read(c, "R6 read after write miss", 0);

        // R7: matching snoop invalidates, foreign tag on same index does not
        snoop(a + 1, 8'hE7);
        do_read(a + 1, "R7 read after matching snoop", 0);
        snoop(a ^ 24'h000200, 8'h11);
        chk(ref_hit(a), "R7 foreign snoop keeps line", ref_hit(a), 1);
        do_read(a + 3, "R7 hit after foreign snoop", 0);

        // R8: snoop of the block under fill
        t = 24'h2A00C1;
        fork
            do_read(t, "R8 read during snoop", 1);
            begin
                @(negedge clk);
                while (!mem_req) @(negedge clk);
                snoop(t + 2, rd_mem(t + 2));
            end
        join
        chk(!ref_hit(t), "R8 line left invalid", ref_hit(t), 0);
        do_read(t, "R8 read after poisoned fill", 0);

        // random mix over few tags and indices
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [AW-1:0] r;
            r = {14'($urandom_range(3, 0)), 2'b00, 4'($urandom_range(3, 0)), 2'($urandom_range(3, 0))};
            op = $urandom_range(9, 0);
            if (op < 5)      do_read(r, "R2 random read", 0);
            else if (op < 8) do_write(r, 8'($urandom));
            else             snoop(r, 8'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule